// File: doc/BRIEF.md
# Power-Good Supervisor with Timeout

This block drives a registered, active-high power-good signal that also serves as the system reset release. It watches a set of per-rail flags: one saying that a switched output has climbed past its good threshold, one saying that the rail's input supply is above its undervoltage limit. It also watches a global enable, a fault flag from the sequencer and an active-low margin request. Power-good rises only after every rail in use has been continuously good for a programmable number of clock cycles. It falls on the next clock edge when any supply, the enable or the fault condition goes bad.

A rail-use mask takes absent rails out of consideration. The timeout count comes from a port. A value below the built-in minimum, including zero when nothing is programmed, falls back to that minimum. While margin is requested, all monitoring is suspended. Power-good and the qualification counter both keep their present values, so supplies can be moved below threshold without causing a reset. The input flags are assumed to be synchronised to the clock already.

Top module: `pwr_good_supervisor`

## Requirements
- R1: After reset, `pwr_good_o` is 0 and stays 0 until a full qualification interval has been observed.
- R2: With margin released and every used rail's flags, `enable_i` high and `fault_i` low, `pwr_good_o` becomes 1 at the clock edge that samples the T-th consecutive all-good cycle, where T is the effective timeout. It is 0 throughout the cycles before that edge.
- R3: The effective timeout T is `timeout_i` when that value is at least `MIN_TIMEOUT`. Otherwise T is `MIN_TIMEOUT`, and this includes `timeout_i` = 0.
- R4: A used rail whose `rail_up_i` bit drops before expiry restarts qualification from zero. A full T good cycles are then needed after the flag returns.
- R5: While `pwr_good_o` is 1 and margin is released, a 0 on `rail_up_i` of a used rail clears `pwr_good_o` at the next clock edge.
- R6: A 0 on `rail_uv_ok_i` of a used rail clears `pwr_good_o` at the next clock edge and restarts qualification.
- R7: A 0 on `enable_i` clears `pwr_good_o` at the next clock edge and restarts qualification.
- R8: A 1 on `fault_i` clears `pwr_good_o` at the next clock edge and restarts qualification.
- R9: While `margin_ni` is 0, `pwr_good_o` keeps its value, whether that is 0 or 1, and all other inputs are ignored. The qualification count is frozen and resumes from the same point when `margin_ni` returns to 1.
- R10: A rail whose `rail_used_i` bit is 0 is treated as permanently good. Its `rail_up_i` and `rail_uv_ok_i` bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rail_up_i | input | NUM_RAILS | Per-rail switched output above its good threshold |
| rail_uv_ok_i | input | NUM_RAILS | Per-rail input supply above its undervoltage limit |
| rail_used_i | input | NUM_RAILS | Per-rail mask, 1 = rail is monitored |
| enable_i | input | 1 | Global enable flag |
| margin_ni | input | 1 | Margin request, active low; freezes monitoring |
| fault_i | input | 1 | Fault or fast-shutdown flag from the sequencer |
| timeout_i | input | CNT_W | Programmed timeout in clock cycles |
| pwr_good_o | output | 1 | Registered power-good / reset release |

## Verification
The bench builds the block with three rails, an 8-bit count and a minimum timeout of 4. It programs a timeout of 6. These small values let each qualification window be walked cycle by cycle. With them, the exact edge where power-good rises can be checked, and so can a restart in the middle of a window. They also make the fallback from an under-minimum count reachable within a few cycles. The third rail is enough to exercise the mask with one rail left absent.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [1:0] {
        PH_DOWN = 2'd0,
        PH_QUAL = 2'd1,
        PH_GOOD = 2'd2
    } pgs_phase_e;

    typedef enum logic [1:0] {
        ACT_RUN   = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_HOLD  = 2'd2
    } pgs_action_e;

endpackage

// File: rtl/pgs_rail_screen.sv
module pgs_rail_screen #(
    parameter int NUM_RAILS = 3
) (
    input  logic [NUM_RAILS-1:0] up_i,
    input  logic [NUM_RAILS-1:0] uv_ok_i,
    input  logic [NUM_RAILS-1:0] used_i,
    output logic                 all_up_o,
    output logic                 all_uv_ok_o
);
    logic [NUM_RAILS-1:0] up_eff;
    logic [NUM_RAILS-1:0] uv_eff;

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        // an unused rail always reads as good
        assign up_eff[g] = ~used_i[g] | up_i[g];
        assign uv_eff[g] = ~used_i[g] | uv_ok_i[g];
    end

    assign all_up_o    = &up_eff;
    assign all_uv_ok_o = &uv_eff;
endmodule

// File: rtl/pgs_target.sv
module pgs_target #(
    parameter int CNT_W       = 16,
    parameter int MIN_TIMEOUT = 8
) (
    input  logic [CNT_W-1:0] timeout_i,
    output logic [CNT_W-1:0] target_o
);
    localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_TIMEOUT);

    always_comb begin
        if (timeout_i < MIN_L) begin
            target_o = MIN_L;
        end else begin
            target_o = timeout_i;
        end
    end
endmodule

// File: rtl/pgs_gate.sv
module pgs_gate
    import pgs_pkg::*;
(
    input  logic        margin_ni,
    input  logic        enable_i,
    input  logic        fault_i,
    input  logic        all_uv_ok_i,
    input  logic        all_up_i,
    output pgs_action_e action_o
);
    always_comb begin
        if (!margin_ni) begin
            action_o = ACT_HOLD;
        end else if (fault_i || !enable_i || !all_uv_ok_i || !all_up_i) begin
            action_o = ACT_CLEAR;
        end else begin
            action_o = ACT_RUN;
        end
    end
endmodule

// File: rtl/pwr_good_supervisor.sv
module pwr_good_supervisor
    import pgs_pkg::*;
#(
    parameter int NUM_RAILS   = 3,
    parameter int CNT_W       = 16,
    parameter int MIN_TIMEOUT = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_RAILS-1:0] rail_up_i,
    input  logic [NUM_RAILS-1:0] rail_uv_ok_i,
    input  logic [NUM_RAILS-1:0] rail_used_i,
    input  logic                 enable_i,
    input  logic                 margin_ni,
    input  logic                 fault_i,
    input  logic [CNT_W-1:0]     timeout_i,
    output logic                 pwr_good_o
);
    typedef struct packed {
        pgs_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             pg;
    } state_t;

    state_t      st_d, st_q;
    logic        all_up, all_uv_ok;
    logic [CNT_W-1:0] target;
    pgs_action_e action;
    logic [CNT_W:0]   cnt_inc;

    pgs_rail_screen #(.NUM_RAILS(NUM_RAILS)) i_screen (
        .up_i        (rail_up_i),
        .uv_ok_i     (rail_uv_ok_i),
        .used_i      (rail_used_i),
        .all_up_o    (all_up),
        .all_uv_ok_o (all_uv_ok)
    );

    pgs_target #(.CNT_W(CNT_W), .MIN_TIMEOUT(MIN_TIMEOUT)) i_target (
        .timeout_i (timeout_i),
        .target_o  (target)
    );

    pgs_gate i_gate (
        .margin_ni   (margin_ni),
        .enable_i    (enable_i),
        .fault_i     (fault_i),
        .all_uv_ok_i (all_uv_ok),
        .all_up_i    (all_up),
        .action_o    (action)
    );

    assign cnt_inc = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};

    always_comb begin
        st_d = st_q;
        unique case (action)
            ACT_HOLD: begin
                st_d = st_q;
            end
            ACT_CLEAR: begin
                st_d.phase = PH_DOWN;
                st_d.cnt   = '0;
                st_d.pg    = 1'b0;
            end
            default: begin
                if (st_q.phase == PH_GOOD) begin
                    st_d.pg = 1'b1;
                end else if (cnt_inc >= {1'b0, target}) begin
                    st_d.phase = PH_GOOD;
                    st_d.cnt   = target;
                    st_d.pg    = 1'b1;
                end else begin
                    st_d.phase = PH_QUAL;
                    st_d.cnt   = cnt_inc[CNT_W-1:0];
                    st_d.pg    = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_DOWN, cnt: '0, pg: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_good_o = st_q.pg;
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
    parameter int NUM_RAILS = 3
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_RAILS-1:0] rail_up_i,
    input logic [NUM_RAILS-1:0] rail_uv_ok_i,
    input logic [NUM_RAILS-1:0] rail_used_i,
    input logic                 enable_i,
    input logic                 margin_ni,
    input logic                 fault_i,
    input logic                 pwr_good_o
);
    AST_MARGIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !margin_ni |=> $stable(pwr_good_o)); // R9
    AST_FAULT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (margin_ni && fault_i) |=> !pwr_good_o); // R8
    AST_ENABLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (margin_ni && !enable_i) |=> !pwr_good_o); // R7
    AST_UV_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (margin_ni && |(rail_used_i & ~rail_uv_ok_i)) |=> !pwr_good_o); // R6
    AST_UP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (margin_ni && |(rail_used_i & ~rail_up_i)) |=> !pwr_good_o); // R5
    AST_RISE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwr_good_o) |-> ($past(margin_ni) && $past(enable_i) && !$past(fault_i)
                               && ($past(rail_used_i & ~rail_up_i) == '0))); // R2
endmodule

bind pwr_good_supervisor pgs_checker #(.NUM_RAILS(NUM_RAILS)) i_pgs_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rail_up_i    (rail_up_i),
    .rail_uv_ok_i (rail_uv_ok_i),
    .rail_used_i  (rail_used_i),
    .enable_i     (enable_i),
    .margin_ni    (margin_ni),
    .fault_i      (fault_i),
    .pwr_good_o   (pwr_good_o)
);

// File: tb/test_pwr_good_supervisor.sv
module test_pwr_good_supervisor;
    localparam int NR = 3;
    localparam int CW = 8;
    localparam int MINT = 4;
    localparam int TO = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] up = '0;
    logic [NR-1:0] uv = '0;
    logic [NR-1:0] used = '1;
    logic          en = 1'b0;
    logic          mrg_n = 1'b1;
    logic          flt = 1'b0;
    logic [CW-1:0] tmo = CW'(TO);
    logic          pg;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwr_good_supervisor #(.NUM_RAILS(NR), .CNT_W(CW), .MIN_TIMEOUT(MINT)) i_pwr_good_supervisor (
        .clk_i(clk), .rst_ni(rst_n), .rail_up_i(up), .rail_uv_ok_i(uv),
        .rail_used_i(used), .enable_i(en), .margin_ni(mrg_n), .fault_i(flt),
        .timeout_i(tmo), .pwr_good_o(pg)
    );

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (pg !== exp) begin
            n_fail++;
            $display("FAIL %s: pwr_good actual=%b expected=%b", req, pg, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic all_good();
        up = '1; uv = '1; used = '1; en = 1'b1; flt = 1'b0; mrg_n = 1'b1;
    endtask

    task automatic idle();
        all_good();
        en = 1'b0;
        step(2);
    endtask

    task automatic bring_up(input string req);
        idle();
        tmo = CW'(TO);
        all_good();
        step(TO);
        check(1'b1, req);
    endtask

    task automatic t_reset();
        step(1);
        check(1'b0, "R1 reset");
        rst_n = 1'b1;
        all_good();
        step(TO - 1);
        check(1'b0, "R1 low before interval");
    endtask

    task automatic t_basic();
        idle();
        tmo = CW'(TO);
        all_good();
        step(TO - 1);
        check(1'b0, "R2 before expiry");
        step(1);
        check(1'b1, "R2 at expiry");
        step(3);
        check(1'b1, "R2 stays high");
    endtask

    task automatic t_min();
        idle();
        tmo = '0;
        all_good();
        step(MINT - 1);
        check(1'b0, "R3 zero count before min");
        step(1);
        check(1'b1, "R3 zero count uses min");
        idle();
        tmo = CW'(2);
        all_good();
        step(MINT - 1);
        check(1'b0, "R3 small count before min");
        step(1);
        check(1'b1, "R3 small count uses min");
    endtask

    task automatic t_restart();
        idle();
        tmo = CW'(TO);
        all_good();
        step(4);
        up[1] = 1'b0;
        step(1);
        up[1] = 1'b1;
        step(TO - 1);
        check(1'b0, "R4 restart not yet expired");
        step(1);
        check(1'b1, "R4 full interval after restart");
    endtask

    task automatic t_drops();
        bring_up("R5 setup");
        up[2] = 1'b0;
        step(1);
        check(1'b0, "R5 rail output drop");
        bring_up("R6 setup");
        uv[0] = 1'b0;
        step(1);
        check(1'b0, "R6 undervoltage drop");
        uv[0] = 1'b1;
        step(TO - 1);
        check(1'b0, "R6 qualification restarted");
        bring_up("R7 setup");
        en = 1'b0;
        step(1);
        check(1'b0, "R7 enable drop");
        bring_up("R8 setup");
        flt = 1'b1;
        step(1);
        check(1'b0, "R8 fault");
    endtask

    task automatic t_margin();
        bring_up("R9 setup high");
        mrg_n = 1'b0;
        up = '0; uv = '0; en = 1'b0; flt = 1'b1;
        step(3);
        check(1'b1, "R9 held high in margin");
        mrg_n = 1'b1;
        step(1);
        check(1'b0, "R9 monitoring resumes");
        idle();
        tmo = CW'(TO);
        all_good();
        step(3);
        mrg_n = 1'b0;
        up = '1; flt = 1'b0;
        step(4);
        check(1'b0, "R9 held low in margin");
        mrg_n = 1'b1;
        step(2);
        check(1'b0, "R9 count frozen, not expired");
        step(1);
        check(1'b1, "R9 count resumed");
    endtask

    task automatic t_mask();
        idle();
        tmo = CW'(TO);
        all_good();
        used = 3'b011;
        up[2] = 1'b0;
        uv[2] = 1'b0;
        step(TO - 1);
        check(1'b0, "R10 masked before expiry");
        step(1);
        check(1'b1, "R10 masked rail ignored");
        up[2] = 1'b1;
        step(2);
        up[2] = 1'b0;
        step(2);
        check(1'b1, "R10 masked toggling has no effect");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_min();
        t_restart();
        t_drops();
        t_margin();
        t_mask();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule